// File: doc/BRIEF.md
# Multiplexed Display Grid Scan and Sync Generator

This block walks a multiplexed fluorescent display through its grids one slot at a time. For each slot it picks which of three segment words reaches the 32 segment outputs. A select input chooses a two-grid or a three-grid scan. A slot lasts `SLOT_BITS` bit times, and one bit time is `CLKS_PER_BIT` clocks. Inside each slot a brightness level sets how long the grid and segment windows stay open. Fixed blanking gaps keep the grid window nested inside the segment window.

As the master, the block runs its own slot timer and drives three active-low grid outputs. It also drives a two-wire slot code, so a second device in follower mode can select the same segment word in step with it. As the follower, it ignores its own timer. It takes the segment word from the incoming code, gates the segments with an incoming brightness pulse, keeps every grid off and drives its own code outputs low. All outputs are registered and reflect the scan state and inputs of the previous clock.

Top module: `vfd_grid_scan`

## Requirements
- R1: While reset is asserted, and on the first clock after it, `grid_n` is 3'b111, `seg_out` is zero and both sync outputs are low.
- R2: With `dup_sel`=1 the master scan covers slots 1 and 2 only. A display cycle lasts 2·`SLOT_BITS` bit times, and `grid_n[2]` never goes low.
- R3: With `dup_sel`=0 the master scan covers slots 1, 2 and 3 in that order. A display cycle lasts 3·`SLOT_BITS` bit times.
- R4: In master mode, with clamped level D, grid k (`grid_n[k-1]`) is low exactly for slot positions 6 to D+5 of slot k. At most one grid is low at a time, and D=0 keeps all grids high.
- R5: In master mode, `seg_out` carries the segment word of the current slot (`latch1`, `latch2`, `latch3` for slots 1 to 3) for slot positions 5 to D+7 when D>0. At every other position it is zero.
- R6: In master mode the sync pair (`sync_out1`,`sync_out2`) is (1,0) in slot 1, (0,1) in slot 2 and (1,1) in slot 3 from slot position 5 onwards. It is (0,0) at positions 0 to 4.
- R7: In follower mode (`master_sel`=0), `grid_n` is 3'b111 and both sync outputs are low. One clock after the inputs, `seg_out` equals the word chosen by the code {`sync_in2`,`sync_in1`} (01 for `latch1`, 10 for `latch2`, 11 for `latch3`) while `dim_in` is 1, and zero while `dim_in` is 0.
- R8: In follower mode the code 00 selects no word, and `seg_out` is zero whatever `dim_in` is.
- R9: In master mode `dim_in`, `sync_in1` and `sync_in2` have no effect on any output.
- R10: A change of `dup_sel` takes effect only at the end of a display cycle. The next cycle starts at slot 1 in the new scan length.
- R11: A `dim_level` above `SLOT_BITS`−8 acts as `SLOT_BITS`−8, which gives the widest windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dup_sel | input | 1 | 1: two-grid scan, 0: three-grid scan |
| master_sel | input | 1 | 1: master (own timer), 0: follower |
| dim_level | input | DIM_W | Brightness level in bit times per slot |
| dim_in | input | 1 | Follower segment enable pulse |
| sync_in1 | input | 1 | Follower slot code, low bit |
| sync_in2 | input | 1 | Follower slot code, high bit |
| latch1 | input | SEG_W | Segment word for grid 1 |
| latch2 | input | SEG_W | Segment word for grid 2 |
| latch3 | input | SEG_W | Segment word for grid 3 |
| seg_out | output | SEG_W | Gated segment word |
| grid_n | output | 3 | Grid drives, active low |
| sync_out1 | output | 1 | Slot code out, low bit |
| sync_out2 | output | 1 | Slot code out, high bit |

## Verification
The bench builds the block with `SLOT_BITS`=64, `CLKS_PER_BIT`=2 and `DIM_W`=6. A full three-grid cycle then takes 384 clocks, so many cycles fit into a short run, including switches of scan length in the middle of a cycle. A 6-bit level reaches 63, above the clamp point of 56, so the saturating path is exercised. The prescaler is still a real divider rather than a constant strobe. Slot positions 0 to 7 keep their meaning at this size, so the blanking gaps are checked in their own sizes.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;

    typedef enum logic [1:0] {
        SLOT_G1 = 2'd0,
        SLOT_G2 = 2'd1,
        SLOT_G3 = 2'd2
    } slot_e;

    // Positions inside a slot, in bit times
    localparam int SEG_LEAD    = 5;  // segments may open from here
    localparam int GRID_LEAD   = 6;  // grid may open from here
    localparam int SEG_END_OFS = 8;  // segments close at level + this
    localparam int SLOT_GAP    = 8;  // bit times a slot keeps dark at full level

    typedef struct packed {
        logic [2:0] grid_n;
        logic       sync2;
        logic       sync1;
    } drive_t;

    localparam drive_t DRIVE_IDLE = '{grid_n: 3'b111, sync2: 1'b0, sync1: 1'b0};

    // Code on the wire: bit 0 = sync line 1, bit 1 = sync line 2
    function automatic logic [1:0] code_of(slot_e s);
        case (s)
            SLOT_G1: return 2'b01;
            SLOT_G2: return 2'b10;
            default: return 2'b11;
        endcase
    endfunction

    function automatic logic [2:0] grid_mask(slot_e s);
        case (s)
            SLOT_G1: return 3'b001;
            SLOT_G2: return 3'b010;
            default: return 3'b100;
        endcase
    endfunction

    function automatic slot_e final_slot(logic two_grid);
        return two_grid ? SLOT_G2 : SLOT_G3;
    endfunction

    function automatic slot_e next_slot(slot_e s);
        case (s)
            SLOT_G1: return SLOT_G2;
            SLOT_G2: return SLOT_G3;
            default: return SLOT_G1;
        endcase
    endfunction

endpackage

// File: rtl/vfd_bit_timer.sv
module vfd_bit_timer #(
    parameter int CLKS_PER_BIT = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (CLKS_PER_BIT <= 1) begin : g_direct
            logic unused_direct;
            assign unused_direct = clk | rst;
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(CLKS_PER_BIT);
            localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst || cnt == LAST) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign tick = (cnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/vfd_slot_seq.sv
module vfd_slot_seq
    import vfd_scan_pkg::*;
#(
    parameter int SLOT_BITS = 1024,
    localparam int POS_W = $clog2(SLOT_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             dup_sel,
    output logic [POS_W-1:0] pos,
    output slot_e            slot,
    output logic             act_dup
);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(SLOT_BITS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos     <= '0;
            slot    <= SLOT_G1;
            act_dup <= dup_sel;
        end else if (tick) begin
            if (pos == POS_LAST) begin
                pos <= '0;
                if (slot == final_slot(act_dup)) begin
                    slot    <= SLOT_G1;
                    act_dup <= dup_sel;   // scan length only changes here
                end else begin
                    slot <= next_slot(slot);
                end
            end else begin
                pos <= pos + 1'b1;
            end
        end
    end
endmodule

// File: rtl/vfd_window_dec.sv
module vfd_window_dec
    import vfd_scan_pkg::*;
#(
    parameter int SLOT_BITS = 1024,
    parameter int DIM_W = 10,
    localparam int POS_W = $clog2(SLOT_BITS)
) (
    input  logic [POS_W-1:0] pos,
    input  logic [DIM_W-1:0] dim_level,
    output logic             grid_on,
    output logic             seg_on,
    output logic             sync_on
);
    localparam int DIM_MAX = SLOT_BITS - SLOT_GAP;
    localparam int CW = POS_W + 2;
    localparam logic [DIM_W-1:0] DIM_CAP = DIM_W'(DIM_MAX);

    logic [DIM_W-1:0] dim_eff;
    logic [CW-1:0]    p_ext;
    logic [CW-1:0]    d_ext;
    logic             lit;

    always_comb begin
        dim_eff = (dim_level > DIM_CAP) ? DIM_CAP : dim_level;
        p_ext   = CW'(pos);
        d_ext   = CW'(dim_eff);
        lit     = (dim_eff != '0);
        grid_on = lit && (p_ext >= CW'(GRID_LEAD)) && (p_ext < d_ext + CW'(GRID_LEAD));
        seg_on  = lit && (p_ext >= CW'(SEG_LEAD))  && (p_ext < d_ext + CW'(SEG_END_OFS));
        sync_on = (p_ext >= CW'(SEG_LEAD));
    end
endmodule

// File: rtl/vfd_grid_scan.sv
module vfd_grid_scan
    import vfd_scan_pkg::*;
#(
    parameter int SEG_W = 32,
    parameter int DIM_W = 10,
    parameter int SLOT_BITS = 1024,
    parameter int CLKS_PER_BIT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dup_sel,
    input  logic             master_sel,
    input  logic [DIM_W-1:0] dim_level,
    input  logic             dim_in,
    input  logic             sync_in1,
    input  logic             sync_in2,
    input  logic [SEG_W-1:0] latch1,
    input  logic [SEG_W-1:0] latch2,
    input  logic [SEG_W-1:0] latch3,
    output logic [SEG_W-1:0] seg_out,
    output logic [2:0]       grid_n,
    output logic             sync_out1,
    output logic             sync_out2
);
    localparam int POS_W = $clog2(SLOT_BITS);

    logic             tick;
    logic [POS_W-1:0] pos;
    slot_e            slot;
    logic             act_dup;
    logic             grid_on;
    logic             seg_on;
    logic             sync_on;

    vfd_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    vfd_slot_seq #(.SLOT_BITS(SLOT_BITS)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .dup_sel (dup_sel),
        .pos     (pos),
        .slot    (slot),
        .act_dup (act_dup)
    );

    vfd_window_dec #(.SLOT_BITS(SLOT_BITS), .DIM_W(DIM_W)) u_win (
        .pos       (pos),
        .dim_level (dim_level),
        .grid_on   (grid_on),
        .seg_on    (seg_on),
        .sync_on   (sync_on)
    );

    // Word table indexed by slot; the fourth entry is never selected
    logic [SEG_W-1:0] words [4];
    assign words[0] = latch1;
    assign words[1] = latch2;
    assign words[2] = latch3;
    assign words[3] = '0;

    logic [1:0]       fol_code;
    drive_t           lead_drv;
    logic [SEG_W-1:0] lead_seg;
    logic [SEG_W-1:0] fol_seg;
    drive_t           drv_q;

    always_comb begin
        lead_drv.grid_n = grid_on ? ~grid_mask(slot) : 3'b111;
        {lead_drv.sync2, lead_drv.sync1} = sync_on ? code_of(slot) : 2'b00;
        lead_seg = seg_on ? words[slot] : '0;

        fol_code = {sync_in2, sync_in1};
        fol_seg  = (dim_in && fol_code != 2'b00) ? words[fol_code - 2'd1] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q   <= DRIVE_IDLE;
            seg_out <= '0;
        end else if (master_sel) begin
            drv_q   <= lead_drv;
            seg_out <= lead_seg;
        end else begin
            drv_q   <= DRIVE_IDLE;
            seg_out <= fol_seg;
        end
    end

    assign grid_n    = drv_q.grid_n;
    assign sync_out1 = drv_q.sync1;
    assign sync_out2 = drv_q.sync2;
endmodule

// File: rtl/vfd_grid_scan_chk.sv
module vfd_grid_scan_chk #(
    parameter int SEG_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             master_sel,
    input logic             sync_in1,
    input logic             sync_in2,
    input logic             act_dup,
    input logic [SEG_W-1:0] latch1,
    input logic [SEG_W-1:0] latch2,
    input logic [SEG_W-1:0] latch3,
    input logic [SEG_W-1:0] seg_out,
    input logic [2:0]       grid_n,
    input logic             sync_out1,
    input logic             sync_out2
);
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R1
    always_ff @(posedge clk) begin
        if (rst_q) begin
            reset_idle_chk: assert (grid_n == 3'b111 && seg_out == '0 && !sync_out1 && !sync_out2)
                else $error("outputs not idle after reset");
        end
    end

    // R2
    two_grid_no_g3_chk: assert property (@(posedge clk) disable iff (rst)
        act_dup |=> grid_n[2]);

    // R4
    single_grid_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~grid_n));

    // R5
    g1_word_chk: assert property (@(posedge clk) disable iff (rst)
        !grid_n[0] |-> seg_out == $past(latch1));
    // R5
    g2_word_chk: assert property (@(posedge clk) disable iff (rst)
        !grid_n[1] |-> seg_out == $past(latch2));
    // R5
    g3_word_chk: assert property (@(posedge clk) disable iff (rst)
        !grid_n[2] |-> seg_out == $past(latch3));

    // R6
    g1_code_chk: assert property (@(posedge clk) disable iff (rst)
        !grid_n[0] |-> (sync_out1 && !sync_out2));
    // R6
    g3_code_chk: assert property (@(posedge clk) disable iff (rst)
        !grid_n[2] |-> (sync_out1 && sync_out2));

    // R7
    follower_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !master_sel |=> (grid_n == 3'b111 && !sync_out1 && !sync_out2));

    // R8
    null_code_chk: assert property (@(posedge clk) disable iff (rst)
        (!master_sel && !sync_in1 && !sync_in2) |=> seg_out == '0);
endmodule

bind vfd_grid_scan vfd_grid_scan_chk #(.SEG_W(SEG_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .master_sel (master_sel),
    .sync_in1   (sync_in1),
    .sync_in2   (sync_in2),
    .act_dup    (act_dup),
    .latch1     (latch1),
    .latch2     (latch2),
    .latch3     (latch3),
    .seg_out    (seg_out),
    .grid_n     (grid_n),
    .sync_out1  (sync_out1),
    .sync_out2  (sync_out2)
);

// File: tb/vfd_grid_scan_test.sv
module vfd_grid_scan_test;
    localparam int SEG_W = 32;
    localparam int DIM_W = 6;
    localparam int SLOT_BITS = 64;
    localparam int CPB = 2;
    localparam int DIM_MAX = SLOT_BITS - 8;
    localparam int DUP_CLKS = 2 * SLOT_BITS * CPB;
    localparam int TRI_CLKS = 3 * SLOT_BITS * CPB;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst = 1'b1;
    logic             dup_sel = 1'b1;
    logic             master_sel = 1'b1;
    logic [DIM_W-1:0] dim_level = 6'd56;
    logic             dim_in = 1'b0;
    logic             sync_in1 = 1'b0;
    logic             sync_in2 = 1'b0;
    logic [SEG_W-1:0] latch1 = 32'hA5A5_0001;
    logic [SEG_W-1:0] latch2 = 32'h0F0F_F0F0;
    logic [SEG_W-1:0] latch3 = 32'h1234_5678;
    logic [SEG_W-1:0] seg_out;
    logic [2:0]       grid_n;
    logic             sync_out1;
    logic             sync_out2;

    vfd_grid_scan #(
        .SEG_W(SEG_W), .DIM_W(DIM_W), .SLOT_BITS(SLOT_BITS), .CLKS_PER_BIT(CPB)
    ) uut (
        .clk(clk), .rst(rst), .dup_sel(dup_sel), .master_sel(master_sel),
        .dim_level(dim_level), .dim_in(dim_in), .sync_in1(sync_in1), .sync_in2(sync_in2),
        .latch1(latch1), .latch2(latch2), .latch3(latch3),
        .seg_out(seg_out), .grid_n(grid_n), .sync_out1(sync_out1), .sync_out2(sync_out2)
    );

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    bit    cmp_en = 0;
    bit    done = 0;
    string tag = "R1";

    // reference model state
    int   m_cnt, m_pos, m_slot;
    bit   m_dup;
    logic [SEG_W-1:0] e_seg;
    logic [2:0]       e_grid;
    logic             e_s1, e_s2;

    function automatic logic [SEG_W-1:0] word_of(int k);
        case (k)
            0: return latch1;
            1: return latch2;
            2: return latch3;
            default: return '0;
        endcase
    endfunction

    always @(posedge clk) begin
        int d;
        int code;
        cyc++;
        if (rst) begin
            e_grid = 3'b111; e_seg = '0; e_s1 = 0; e_s2 = 0;
            m_cnt = 0; m_pos = 0; m_slot = 0; m_dup = dup_sel;
        end else begin
            d = (dim_level > DIM_MAX) ? DIM_MAX : int'(dim_level);
            if (master_sel) begin
                e_grid = 3'b111;
                if (d != 0 && m_pos >= 6 && m_pos < d + 6) e_grid[m_slot] = 1'b0;
                e_seg = (d != 0 && m_pos >= 5 && m_pos < d + 8) ? word_of(m_slot) : '0;
                if (m_pos >= 5) begin
                    e_s1 = (m_slot != 1);
                    e_s2 = (m_slot != 0);
                end else begin
                    e_s1 = 0; e_s2 = 0;
                end
            end else begin
                code = {sync_in2, sync_in1};
                e_grid = 3'b111; e_s1 = 0; e_s2 = 0;
                e_seg = (dim_in && code != 0) ? word_of(code - 1) : '0;
            end
            if (m_cnt == CPB - 1) begin
                m_cnt = 0;
                if (m_pos == SLOT_BITS - 1) begin
                    m_pos = 0;
                    if (m_slot == (m_dup ? 1 : 2)) begin
                        m_slot = 0;
                        m_dup = dup_sel;
                    end else begin
                        m_slot++;
                    end
                end else begin
                    m_pos++;
                end
            end else begin
                m_cnt++;
            end
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            checks++;
            if (seg_out !== e_seg || grid_n !== e_grid || sync_out1 !== e_s1 || sync_out2 !== e_s2) begin
                errors++;
                $display("FAIL %s cyc=%0d seg=%h/%h grid=%b/%b sync=%b%b/%b%b (actual/expected)",
                         tag, cyc, seg_out, e_seg, grid_n, e_grid, sync_out2, sync_out1, e_s2, e_s1);
            end
        end
    end

    // port monitor for timing measurements
    bit prev_g1 = 1;
    int g1_fall = 0, g1_period = 0, g1_len = 0, g3_low = 0, any_low = 0;
    always @(negedge clk) begin
        if (prev_g1 && !grid_n[0]) begin
            g1_period = cyc - g1_fall;
            g1_fall = cyc;
        end
        if (!prev_g1 && grid_n[0]) g1_len = cyc - g1_fall;
        prev_g1 = grid_n[0];
        if (!grid_n[2]) g3_low++;
        if (grid_n != 3'b111) any_low++;
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        run(3);
        cmp_en = 1;
        // R1: reset state seen at the ports
        check(grid_n == 3'b111, "R1", "grid_n in reset", grid_n, 7);
        check(seg_out == '0, "R1", "seg_out in reset", int'(seg_out != 0), 0);
        check(!sync_out1 && !sync_out2, "R1", "sync in reset", {sync_out2, sync_out1}, 0);
        rst = 1'b0;

        // R2: two-grid scan at full level
        tag = "R2";
        g3_low = 0;
        run(3 * DUP_CLKS);
        check(g1_period == DUP_CLKS, "R2", "two-grid cycle clocks", g1_period, DUP_CLKS);
        check(g3_low == 0, "R2", "grid 3 low clocks", g3_low, 0);
        check(g1_len == DIM_MAX * CPB, "R4", "grid 1 window at full level", g1_len, DIM_MAX * CPB);

        // R10: switch to three grids in mid cycle; R3 after it settles
        run(DUP_CLKS / 3);
        tag = "R10";
        dup_sel = 1'b0;
        run(DUP_CLKS);
        tag = "R3";
        g3_low = 0;
        run(3 * TRI_CLKS);
        check(g1_period == TRI_CLKS, "R3", "three-grid cycle clocks", g1_period, TRI_CLKS);
        check(g3_low == DIM_MAX * CPB * 3, "R3", "grid 3 low clocks over 3 cycles", g3_low, DIM_MAX * CPB * 3);

        // R4: reduced level, then zero
        tag = "R4";
        dim_level = 6'd20;
        run(2 * TRI_CLKS);
        check(g1_len == 20 * CPB, "R4", "grid 1 window at level 20", g1_len, 20 * CPB);
        dim_level = 6'd0;
        run(2);
        any_low = 0;
        run(TRI_CLKS);
        check(any_low == 0, "R4", "grid low clocks at level 0", any_low, 0);

        // R11: level above the cap
        tag = "R11";
        dim_level = 6'd63;
        run(2 * TRI_CLKS);
        check(g1_len == DIM_MAX * CPB, "R11", "grid 1 window at level 63", g1_len, DIM_MAX * CPB);

        // R9: follower inputs toggling in master mode
        tag = "R9";
        dim_level = 6'd30;
        for (int i = 0; i < 2 * TRI_CLKS; i++) begin
            @(negedge clk);
            {sync_in2, sync_in1, dim_in} = 3'($urandom);
        end
        check(g1_len == 30 * CPB, "R9", "grid 1 window with noisy inputs", g1_len, 30 * CPB);

        // R5: segment words changing while scanning
        tag = "R5";
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            latch1 = $urandom; latch2 = $urandom; latch3 = $urandom;
            dim_level = 6'($urandom_range(0, 63));
            run(37);
        end

        // R6: code pattern under a steady scan
        tag = "R6";
        dim_level = 6'd56;
        run(2 * TRI_CLKS);

        // R7 and R8: follower mode
        master_sel = 1'b0;
        for (int c = 0; c < 4; c++) begin
            for (int di = 0; di < 2; di++) begin
                @(negedge clk);
                tag = (c == 0) ? "R8" : "R7";
                {sync_in2, sync_in1} = 2'(c);
                dim_in = di[0];
                run(2);
                check(grid_n == 3'b111, "R7", "follower grid_n", grid_n, 7);
                check(!sync_out1 && !sync_out2, "R7", "follower sync out", {sync_out2, sync_out1}, 0);
                if (c == 0)
                    check(seg_out == '0, "R8", "null code segments", int'(seg_out != 0), 0);
                else
                    check(seg_out == (di ? word_of(c - 1) : '0), "R7", "follower segments",
                          int'(seg_out[15:0]), int'(di ? word_of(c - 1) & 32'hFFFF : 0));
            end
        end

        // R10: back to master, switch to two grids in mid cycle
        tag = "R10";
        master_sel = 1'b1;
        run(TRI_CLKS / 2);
        dup_sel = 1'b1;
        g3_low = 0;
        run(TRI_CLKS + 3 * DUP_CLKS);
        check(g1_period == DUP_CLKS, "R10", "cycle clocks after switch", g1_period, DUP_CLKS);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule